// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block turns a stereo PCM bit stream into parallel sample words. It takes a bit clock, a serial data line and a frame clock. All three are treated as asynchronous to the system clock and are sampled through a short synchronizer. Data is taken on each rising edge of the bit clock. A change of frame-clock level marks the boundary between two channel half-frames. When a half-frame ends, the word it carried is sign-extended to 24 bits and placed on the left or right output. The matching valid output goes high for one system-clock cycle.

Three run-time controls set how the stream is read:
- **Framing**: right-justified, where the word ends at the frame boundary, or I2S, where the word starts one bit after it.
- **Channel polarity**: which frame-clock level means left.
- **Word length**: 16, 20 or 24 bits.

The controls are taken at the start of each half-frame. Changing them in the middle of a half-frame only affects the next one.

The control flow is a state machine with five states:
- `RX_INIT` takes the first bit-clock edge after reset to learn the current frame-clock level, then goes to `RX_WAIT`.
- `RX_WAIT` skips the half-frame that was already in progress at reset.
- On every frame-clock transition, any of `RX_WAIT`, `RX_RJ_RUN`, `RX_I2S_TAKE` or `RX_I2S_FULL` starts a new half-frame. It goes to `RX_I2S_TAKE` when I2S framing is selected, and to `RX_RJ_RUN` otherwise.
- `RX_RJ_RUN` keeps shifting every bit, so the last bits before the boundary remain.
- `RX_I2S_TAKE` collects bits until the selected word length is reached, then goes to `RX_I2S_FULL`.
- `RX_I2S_FULL` ignores bits until the next boundary.

A transition out of `RX_RJ_RUN`, `RX_I2S_TAKE` or `RX_I2S_FULL` delivers the finished word. A transition out of `RX_WAIT` delivers nothing.

Top module: `aud_serial_rx`

## Requirements
- R1: In right-justified mode (`fmt_i2s_i` = 0), the word is the last N bits sampled before the frame-clock transition, MSB first. Bits earlier in that half-frame have no effect on it.
- R2: In I2S mode (`fmt_i2s_i` = 1), the bit sampled at the first bit-clock rising edge after the transition is skipped. The next N bits form the word, MSB first. Bits after those N have no effect.
- R3: With `lr_swap_i` = 0, a half-frame with the frame clock high is delivered on `left_o`/`left_vld_o`. One with the frame clock low is delivered on `right_o`/`right_vld_o`.
- R4: With `lr_swap_i` = 1, the channel assignment is swapped: high goes to right and low goes to left.
- R5: `wlen_i` sets N: 2'b00 gives 16, 2'b01 gives 20, 2'b10 gives 24. The reserved code 2'b11 acts as 16.
- R6: A word of N bits is sign-extended to 24 bits: output bits 23 down to N copy bit N-1.
- R7: Each completed half-frame produces exactly one valid pulse, one system clock long. `left_vld_o` and `right_vld_o` are never high together. The data output holds its value until the next word for that channel.
- R8: The half-frame already in progress when reset is released produces no word.
- R9: The framing, polarity and length controls are taken at the start of each half-frame. A change during a half-frame affects only the following half-frame.
- R10: During reset, both data outputs are zero and both valid outputs are low.
- R11: Data is taken only at the rising edge of the bit clock. A data change while the bit clock is high has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Serial bit clock |
| lrclk_i | input | 1 | Frame clock; its level selects the channel |
| sdata_i | input | 1 | Serial data |
| fmt_i2s_i | input | 1 | 0: right-justified, 1: I2S framing |
| lr_swap_i | input | 1 | 0: high level is left, 1: high level is right |
| wlen_i | input | 2 | Word length code (00:16, 01:20, 10:24, 11:16) |
| left_o | output | 24 | Last left sample, sign-extended |
| right_o | output | 24 | Last right sample, sign-extended |
| left_vld_o | output | 1 | One-cycle pulse when `left_o` is updated |
| right_vld_o | output | 1 | One-cycle pulse when `right_o` is updated |

## Verification
Two events share one bit-clock edge: delivering the word that is ending and starting the next half-frame. The start includes loading new controls and, in right-justified mode, taking the first bit of the new half-frame. The bench changes the controls in the middle of almost every half-frame, so at each boundary the outgoing word must still be decoded with the old settings while the new half-frame uses the new ones. A scoreboard judges each delivered word against a value computed from the settings that applied when its half-frame began.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

    // Widest word the receiver can deliver and the counter width it needs
    localparam int unsigned SMP_W = 24;
    localparam int unsigned CNT_W = $clog2(SMP_W + 1);

    typedef enum logic [2:0] {
        RX_INIT,
        RX_WAIT,
        RX_RJ_RUN,
        RX_I2S_TAKE,
        RX_I2S_FULL
    } rx_state_e;

    typedef struct packed {
        logic       i2s;
        logic       swap;
        logic [1:0] wlen;
    } rx_cfg_t;

    // Word length code to bit count; the spare code falls back to 16
    function automatic logic [CNT_W-1:0] wlen_bits(input logic [1:0] code);
        logic [CNT_W-1:0] n;
        unique case (code)
            2'b01:   n = CNT_W'(20);
            2'b10:   n = CNT_W'(24);
            default: n = CNT_W'(16);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/aud_rx_sync.sv
module aud_rx_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_i,
    input  logic lrclk_i,
    input  logic sdata_i,
    output logic bit_stb_o,
    output logic bit_dat_o,
    output logic lr_lvl_o
);
    localparam int unsigned TOP = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] bclk_sh;
    logic [SYNC_STAGES-1:0] lr_sh;
    logic [SYNC_STAGES-1:0] dat_sh;
    logic                   bclk_prev_q;

    // All three lines travel through the same number of stages so that
    // data and frame level stay aligned with the bit-clock edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bclk_sh     <= '0;
            lr_sh       <= '0;
            dat_sh      <= '0;
            bclk_prev_q <= 1'b0;
        end else begin
            bclk_sh     <= {bclk_sh[SYNC_STAGES-2:0], bclk_i};
            lr_sh       <= {lr_sh[SYNC_STAGES-2:0], lrclk_i};
            dat_sh      <= {dat_sh[SYNC_STAGES-2:0], sdata_i};
            bclk_prev_q <= bclk_sh[TOP];
        end
    end

    assign bit_stb_o = bclk_sh[TOP] & ~bclk_prev_q;
    assign bit_dat_o = dat_sh[TOP];
    assign lr_lvl_o  = lr_sh[TOP];

    // R11: a strobe marks one rising edge only, never two cycles running
    p_single_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb_o |=> !bit_stb_o);

endmodule

// File: rtl/aud_rx_frame.sv
module aud_rx_frame
    import aud_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_stb_i,
    input  logic             bit_dat_i,
    input  logic             lr_lvl_i,
    input  rx_cfg_t          cfg_i,
    output logic             word_stb_o,
    output logic             word_left_o,
    output logic [SMP_W-1:0] word_raw_o,
    output logic [CNT_W-1:0] word_n_o
);
    rx_state_e        state_q, state_d, start_st;
    rx_cfg_t          cfg_q;
    logic             lr_prev_q;
    logic [SMP_W-1:0] sreg_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] n_cur;
    logic             lr_edge;
    logic             shifting;

    logic             word_stb_q;
    logic             word_left_q;
    logic [SMP_W-1:0] word_raw_q;
    logic [CNT_W-1:0] word_n_q;

    assign n_cur    = wlen_bits(cfg_q.wlen);
    assign lr_edge  = bit_stb_i && (lr_lvl_i != lr_prev_q) && (state_q != RX_INIT);
    assign start_st = cfg_i.i2s ? RX_I2S_TAKE : RX_RJ_RUN;
    assign shifting = (state_q == RX_RJ_RUN) || (state_q == RX_I2S_TAKE);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_INIT: begin
                if (bit_stb_i) state_d = RX_WAIT;
            end
            RX_WAIT, RX_RJ_RUN, RX_I2S_FULL: begin
                if (lr_edge) state_d = start_st;
            end
            RX_I2S_TAKE: begin
                if (lr_edge) begin
                    state_d = start_st;
                end else if (bit_stb_i && ((cnt_q + 1'b1) == n_cur)) begin
                    state_d = RX_I2S_FULL;
                end
            end
            default: state_d = RX_INIT;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_INIT;
        else        state_q <= state_d;
    end

    // Shift path and delivered-word registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lr_prev_q   <= 1'b0;
            cfg_q       <= '0;
            sreg_q      <= '0;
            cnt_q       <= '0;
            word_stb_q  <= 1'b0;
            word_left_q <= 1'b0;
            word_raw_q  <= '0;
            word_n_q    <= CNT_W'(16);
        end else begin
            word_stb_q <= 1'b0;
            if (bit_stb_i) lr_prev_q <= lr_lvl_i;
            if (lr_edge) begin
                if (state_q != RX_WAIT) begin
                    word_stb_q  <= 1'b1;
                    word_raw_q  <= sreg_q;
                    word_n_q    <= n_cur;
                    word_left_q <= lr_prev_q ^ cfg_q.swap;
                end
                cfg_q  <= cfg_i;
                cnt_q  <= '0;
                sreg_q <= cfg_i.i2s ? '0 : {{(SMP_W-1){1'b0}}, bit_dat_i};
            end else if (bit_stb_i && shifting) begin
                sreg_q <= {sreg_q[SMP_W-2:0], bit_dat_i};
                if (state_q == RX_I2S_TAKE) cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign word_stb_o  = word_stb_q;
    assign word_left_o = word_left_q;
    assign word_raw_o  = word_raw_q;
    assign word_n_o    = word_n_q;

    // R8: nothing leaves before the first complete half-frame has begun
    p_quiet_before_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_INIT || state_q == RX_WAIT) |=> !word_stb_q);

    // R2: the I2S word stops exactly at the selected length
    p_full_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_I2S_FULL) |-> (cfg_q.i2s && (cnt_q == n_cur)));

    // R1: the running shifter is only used for right-justified framing
    p_run_is_rj_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_RJ_RUN) |-> !cfg_q.i2s);

    // R5: a delivered length is always one of the three legal sizes
    p_word_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb_q |-> (word_n_q == CNT_W'(16) || word_n_q == CNT_W'(20)
                        || word_n_q == CNT_W'(24)));

endmodule

// File: rtl/aud_rx_out.sv
module aud_rx_out
    import aud_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             word_stb_i,
    input  logic             word_left_i,
    input  logic [SMP_W-1:0] word_raw_i,
    input  logic [CNT_W-1:0] word_n_i,
    output logic [SMP_W-1:0] left_o,
    output logic [SMP_W-1:0] right_o,
    output logic             left_vld_o,
    output logic             right_vld_o
);
    logic [SMP_W-1:0] ext;
    logic             sign;
    logic [SMP_W-1:0] left_q, right_q;
    logic [CNT_W-1:0] left_n_q, right_n_q;
    logic             left_vld_q, right_vld_q;

    assign sign = word_raw_i[word_n_i - 1'b1];

    // Each output bit either keeps its own received bit or copies the sign
    for (genvar b = 0; b < SMP_W; b++) begin : g_ext
        assign ext[b] = (CNT_W'(b) < word_n_i) ? word_raw_i[b] : sign;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q      <= '0;
            right_q     <= '0;
            left_n_q    <= CNT_W'(16);
            right_n_q   <= CNT_W'(16);
            left_vld_q  <= 1'b0;
            right_vld_q <= 1'b0;
        end else begin
            left_vld_q  <= word_stb_i && word_left_i;
            right_vld_q <= word_stb_i && !word_left_i;
            if (word_stb_i && word_left_i) begin
                left_q   <= ext;
                left_n_q <= word_n_i;
            end
            if (word_stb_i && !word_left_i) begin
                right_q   <= ext;
                right_n_q <= word_n_i;
            end
        end
    end

    assign left_o      = left_q;
    assign right_o     = right_q;
    assign left_vld_o  = left_vld_q;
    assign right_vld_o = right_vld_q;

    // R7: the two channels never report in the same cycle
    p_one_side_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(left_vld_q && right_vld_q));

    // R7: each valid is a single-cycle pulse
    p_left_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        left_vld_q |=> !left_vld_q);
    p_right_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        right_vld_q |=> !right_vld_q);

    // R7: the data holds between its pulses
    p_left_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !left_vld_q |-> $stable(left_q));

    // R6: the top bit agrees with the received sign bit
    p_sign_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        left_vld_q |-> (left_q[SMP_W-1] == left_q[left_n_q - 1'b1]));

endmodule

// File: rtl/aud_serial_rx.sv
module aud_serial_rx
    import aud_rx_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bclk_i,
    input  logic        lrclk_i,
    input  logic        sdata_i,
    input  logic        fmt_i2s_i,
    input  logic        lr_swap_i,
    input  logic [1:0]  wlen_i,
    output logic [23:0] left_o,
    output logic [23:0] right_o,
    output logic        left_vld_o,
    output logic        right_vld_o
);
    logic             bit_stb, bit_dat, lr_lvl;
    rx_cfg_t          cfg_pins;
    logic             word_stb, word_left;
    logic [SMP_W-1:0] word_raw;
    logic [CNT_W-1:0] word_n;

    assign cfg_pins = '{i2s: fmt_i2s_i, swap: lr_swap_i, wlen: wlen_i};

    aud_rx_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk_i    (bclk_i),
        .lrclk_i   (lrclk_i),
        .sdata_i   (sdata_i),
        .bit_stb_o (bit_stb),
        .bit_dat_o (bit_dat),
        .lr_lvl_o  (lr_lvl)
    );

    aud_rx_frame u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_stb_i   (bit_stb),
        .bit_dat_i   (bit_dat),
        .lr_lvl_i    (lr_lvl),
        .cfg_i       (cfg_pins),
        .word_stb_o  (word_stb),
        .word_left_o (word_left),
        .word_raw_o  (word_raw),
        .word_n_o    (word_n)
    );

    aud_rx_out u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .word_stb_i  (word_stb),
        .word_left_i (word_left),
        .word_raw_i  (word_raw),
        .word_n_i    (word_n),
        .left_o      (left_o),
        .right_o     (right_o),
        .left_vld_o  (left_vld_o),
        .right_vld_o (right_vld_o)
    );

endmodule

// File: tb/aud_serial_rx_tb_top.sv
module aud_serial_rx_tb_top;

    typedef struct packed {
        logic       i2s;
        logic       swap;
        logic [1:0] wl;
    } tcfg_t;

    typedef struct {
        logic        is_left;
        logic [23:0] val;
        string       tag;
    } exp_t;

    localparam tcfg_t C_RJ16   = '{1'b0, 1'b0, 2'b00};
    localparam tcfg_t C_RJ20   = '{1'b0, 1'b0, 2'b01};
    localparam tcfg_t C_RJ24   = '{1'b0, 1'b0, 2'b10};
    localparam tcfg_t C_RJRSV  = '{1'b0, 1'b0, 2'b11};
    localparam tcfg_t C_I2S16  = '{1'b1, 1'b0, 2'b00};
    localparam tcfg_t C_I2S20  = '{1'b1, 1'b0, 2'b01};
    localparam tcfg_t C_I2S24  = '{1'b1, 1'b0, 2'b10};
    localparam tcfg_t C_RJ16S  = '{1'b0, 1'b1, 2'b00};
    localparam tcfg_t C_I2S24S = '{1'b1, 1'b1, 2'b10};
    localparam logic [63:0] JUNK = 64'hC3A5_5A3C_9E17_E169;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk = 1'b0, lrclk = 1'b0, sdata = 1'b0;
    logic        fmt_i2s = 1'b0, lr_swap = 1'b0;
    logic [1:0]  wlen = 2'b00;
    logic [23:0] left_o, right_o;
    logic        left_vld_o, right_vld_o;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    int   vld_seen = 0;
    int   pushed = 0;
    bit   finished = 1'b0;
    bit   prev_vld = 1'b0;
    logic lr_lvl = 1'b0;

    always #2 clk = ~clk;

    aud_serial_rx dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bclk_i      (bclk),
        .lrclk_i     (lrclk),
        .sdata_i     (sdata),
        .fmt_i2s_i   (fmt_i2s),
        .lr_swap_i   (lr_swap),
        .wlen_i      (wlen),
        .left_o      (left_o),
        .right_o     (right_o),
        .left_vld_o  (left_vld_o),
        .right_vld_o (right_vld_o)
    );

    function automatic int width_of(input logic [1:0] wl);
        return (wl == 2'b01) ? 20 : (wl == 2'b10) ? 24 : 16;
    endfunction

    function automatic logic [23:0] sext(input logic [23:0] w, input int n);
        logic [23:0] r;
        r = w;
        for (int b = n; b < 24; b++) r[b] = w[n-1];
        return r;
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [24:0] act, input logic [24:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic apply_cfg(input tcfg_t c);
        fmt_i2s = c.i2s;
        lr_swap = c.swap;
        wlen    = c.wl;
    endtask

    // Drives one half-frame of len bits. The word is placed by the framing in
    // cur; the pins switch to nxt halfway through. While the bit clock is
    // high the data line is inverted to show it is ignored (R11).
    task automatic drive_half(input tcfg_t cur, input tcfg_t nxt, input int len,
                              input logic [23:0] w, input bit expect_it,
                              input string tag);
        logic [63:0] bits;
        int          n;
        exp_t        e;
        n      = width_of(cur.wl);
        lr_lvl = ~lr_lvl;
        bits   = JUNK ^ {40'd0, w};
        if (!cur.i2s) begin
            for (int k = 0; k < n; k++) bits[len-n+k] = w[n-1-k];
        end else begin
            for (int k = 0; k < n; k++) bits[1+k] = w[n-1-k];
        end
        if (expect_it) begin
            e.is_left = lr_lvl ^ cur.swap;
            e.val     = sext(w, n);
            e.tag     = tag;
            exp_q.push_back(e);
            pushed++;
        end
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            bclk  = 1'b0;
            lrclk = lr_lvl;
            sdata = bits[i];
            if (i == len / 2) apply_cfg(nxt);
            repeat (3) @(negedge clk);
            bclk = 1'b1;
            repeat (2) @(negedge clk);
            sdata = ~bits[i];
            repeat (2) @(negedge clk);
        end
    endtask

    // Scoreboard monitor: pops one expectation per valid pulse
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (left_vld_o && right_vld_o)
                check(1'b0, "R7 both valids", 25'd3, 25'd1);
            if (left_vld_o || right_vld_o) begin
                vld_seen++;
                if (prev_vld) check(1'b0, "R7 pulse width", 25'd2, 25'd1);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8/R7 unexpected word",
                          {left_vld_o, left_vld_o ? left_o : right_o}, 25'd0);
                end else begin
                    exp_t e;
                    logic [24:0] act;
                    e   = exp_q.pop_front();
                    act = {left_vld_o, left_vld_o ? left_o : right_o};
                    check(act == {e.is_left, e.val}, e.tag, act, {e.is_left, e.val});
                end
            end
            prev_vld = left_vld_o || right_vld_o;
        end
    end

    initial begin
        apply_cfg(C_RJ16);
        repeat (5) @(negedge clk);
        // R10 reset state
        check(left_o == 24'd0, "R10 left_o in reset", {1'b0, left_o}, 25'd0);
        check(right_o == 24'd0, "R10 right_o in reset", {1'b0, right_o}, 25'd0);
        check(!left_vld_o && !right_vld_o, "R10 valids in reset",
              {23'd0, left_vld_o, right_vld_o}, 25'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R8: half-frame in progress at reset release
        drive_half(C_RJ16, C_RJ16, 10, 24'h5A5A5A, 1'b0, "R8");
        drive_half(C_RJ16, C_RJ16, 32, 24'hAB8001, 1'b1, "R1 rj16 neg");
        check(vld_seen == 0, "R8 no word from partial half",
              25'(vld_seen), 25'd0);
        drive_half(C_RJ16, C_RJ20, 32, 24'h127FFE, 1'b1, "R3 rj16 left");
        drive_half(C_RJ20, C_RJ20, 32, 24'hF80123, 1'b1, "R5 rj20 neg");
        drive_half(C_RJ20, C_RJ24, 32, 24'h07ABCD, 1'b1, "R9 rj20 then 24");
        drive_half(C_RJ24, C_RJ24, 24, 24'h812345, 1'b1, "R1 rj24 no junk");
        drive_half(C_RJ24, C_RJRSV, 24, 24'h3FEDCB, 1'b1, "R6 rj24 pos");
        drive_half(C_RJRSV, C_RJRSV, 32, 24'h66C001, 1'b1, "R5 reserved code");
        drive_half(C_RJRSV, C_I2S16, 32, 24'h004321, 1'b1, "R9 rsv then i2s");
        drive_half(C_I2S16, C_I2S16, 32, 24'hE19ABC, 1'b1, "R2 i2s16 neg");
        drive_half(C_I2S16, C_I2S20, 32, 24'h0F1234, 1'b1, "R2 i2s16 pos");
        drive_half(C_I2S20, C_I2S24, 32, 24'hA8F00D, 1'b1, "R5 i2s20 neg");
        drive_half(C_I2S24, C_I2S24, 32, 24'hC0FFEE, 1'b1, "R2 i2s24 neg");
        drive_half(C_I2S24, C_I2S24, 25, 24'h5EED11, 1'b1, "R2 i2s24 exact");
        drive_half(C_I2S24, C_RJ16S, 25, 24'h9ABCDE, 1'b1, "R9 i2s then swap");
        drive_half(C_RJ16S, C_RJ16S, 32, 24'h00F00F, 1'b1, "R4 rj16 swapped");
        drive_half(C_RJ16S, C_I2S24S, 32, 24'h1B2C3D, 1'b1, "R4 rj16 swapped 2");
        drive_half(C_I2S24S, C_I2S24S, 32, 24'h8000A5, 1'b1, "R4 i2s24 swapped");
        drive_half(C_I2S24S, C_RJ16, 32, 24'h7FFFFF, 1'b1, "R6 i2s24 max pos");
        drive_half(C_RJ16, C_RJ16, 8, 24'h000000, 1'b0, "R7 trailer");
        repeat (40) @(negedge clk);

        check(exp_q.size() == 0, "R7 all words delivered",
              25'(exp_q.size()), 25'd0);
        check(vld_seen == pushed, "R7 one pulse per half-frame",
              25'(vld_seen), 25'(pushed));
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog R7 actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule